// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Processor Core

A 32-bit processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. It runs a fixed nine-instruction subset: word load and store, four register-to-register arithmetic and logic operations, signed set-on-less-than, branch on equality and absolute jump. Every instruction finishes in one cycle, so the core keeps instruction storage and data storage as two separate word arrays. The test environment fills both arrays directly while reset is held.

Each cycle the program counter addresses instruction storage. The register file supplies two operands. The ALU computes either an arithmetic result, a load/store address or an equality test. Multiplexers then choose the write-back source, the second ALU operand, the destination register field and the next program counter. The program counter and the register-file write port are brought out to the ports, so that execution can be followed cycle by cycle.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is set to 0 and every register is cleared. The first instruction after reset is fetched from word 0, and its source registers read as 0.
- R2: An instruction that is not a taken branch and not a jump sets the next PC to PC+4.
- R3: With opcode 0x00, funct 0x20/0x22/0x24/0x25 write rs+rt, rs-rt, rs&rt and rs|rt (modulo 2^32) to register rd (bits 15:11). rs is bits 25:21 and rt is bits 20:16.
- R4: With opcode 0x00 and funct 0x2A, rd receives 1 when rs < rt as signed 32-bit values and 0 otherwise.
- R5: Opcode 0x23 writes into rt the data word at index bits [7:2] of rs plus the sign-extended immediate (bits 15:0).
- R6: Opcode 0x2B stores rt into the data word at index bits [7:2] of rs plus the sign-extended immediate, and writes no register.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to {PC+4 bits 31:28, instruction bits 25:0, 2'b00}.
- R9: Register 0 always reads as 0. A write aimed at register 0 is dropped, and `wb_en_o` stays low for it.
- R10: Any other opcode, and any opcode-0 funct other than the five listed, writes no register and no data word and advances the PC by 4.
- R11: The write port outputs show the current instruction's write while it executes. The register takes the value at the next rising edge, and an instruction in the following cycle reads the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Address of the instruction now executing |
| wb_en_o | output | 1 | High when this instruction writes a nonzero register |
| wb_addr_o | output | 5 | Destination register of the write |
| wb_data_o | output | 32 | Value being written |

## Verification
A corrupted register, data word or program counter becomes visible at the ports within a few instructions. A wrong PC appears on `pc_o` in the very next cycle, and its effect on control flow shows up as a mismatch from then on. A wrong register or data word only shows when a later instruction reads it, so the programs reuse eight registers densely and load back the addresses that stores have touched, which keeps that delay to a handful of cycles. A cycle-by-cycle reference model compares the PC and the full write port on every instruction, so the first wrong cycle is reported.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_fn_e;

   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_LOAD = 6'h23;
   localparam logic [5:0] OPC_STOR = 6'h2B;
   localparam logic [5:0] OPC_BEQ  = 6'h04;
   localparam logic [5:0] OPC_JMP  = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef struct packed {
      logic    reg_we;
      logic    dst_rd;
      logic    use_imm;
      logic    mem_rd;
      logic    mem_we;
      logic    is_beq;
      logic    is_jmp;
      alu_fn_e fn;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_cpu_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl = '0;
      ctrl.fn = ALU_ADD;
      unique case (opcode)
         OPC_REG: begin
            ctrl.reg_we = 1'b1;
            ctrl.dst_rd = 1'b1;
            unique case (funct)
               FN_ADD:  ctrl.fn = ALU_ADD;
               FN_SUB:  ctrl.fn = ALU_SUB;
               FN_AND:  ctrl.fn = ALU_AND;
               FN_OR:   ctrl.fn = ALU_OR;
               FN_SLT:  ctrl.fn = ALU_SLT;
               default: ctrl.reg_we = 1'b0;
            endcase
         end
         OPC_LOAD: begin
            ctrl.reg_we  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.mem_rd  = 1'b1;
         end
         OPC_STOR: begin
            ctrl.use_imm = 1'b1;
            ctrl.mem_we  = 1'b1;
         end
         OPC_BEQ: begin
            ctrl.is_beq = 1'b1;
            ctrl.fn     = ALU_SUB;
         end
         OPC_JMP: ctrl.is_jmp = 1'b1;
         default: ctrl.fn = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_cpu_pkg::*;
#(
   parameter int  W          = 32,
   parameter bit  SLT_SIGNED = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_fn_e      fn,
   output logic [W-1:0] y,
   output logic         zero
);

   logic lt;

   generate
      if (SLT_SIGNED) begin : g_signed_cmp
         assign lt = $signed(a) < $signed(b);
      end else begin : g_unsigned_cmp
         assign lt = a < b;
      end
   endgenerate

   always_comb begin
      unique case (fn)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

   always_comb begin
      AST_SUB_ZERO_EQ: assert (fn != ALU_SUB || zero == (a == b)); // R7
   end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W = 32,
   parameter int N = 32,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2
);

   logic [N-1:0][W-1:0] bank;

   always_ff @(posedge clk) begin
      if (rst) begin
         bank <= '0;
      end else if (we && wa != '0) begin
         bank[wa] <= wd;
      end
   end

   assign rd1 = (ra1 == '0) ? '0 : bank[ra1];
   assign rd2 = (ra2 == '0) ? '0 : bank[ra2];

   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
      (we && wa != '0) |=> (ra1 != $past(wa)) || (rd1 == $past(wd))); // R11

endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
   import sc_cpu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREGS      = 32,
   parameter int IMEM_WORDS = 256,
   parameter int DMEM_WORDS = 64
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] pc_o,
   output logic        wb_en_o,
   output logic [4:0]  wb_addr_o,
   output logic [31:0] wb_data_o
);

   localparam int IAW = $clog2(IMEM_WORDS);
   localparam int DAW = $clog2(DMEM_WORDS);
   localparam int RAW = $clog2(NREGS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("sc_cpu: XLEN must be 32");
      end
      if (RAW != 5) begin : g_bad_nregs
         $error("sc_cpu: register fields are 5 bits, NREGS must be 32");
      end
      if ((1 << IAW) != IMEM_WORDS || (1 << DAW) != DMEM_WORDS) begin : g_bad_depth
         $error("sc_cpu: memory depths must be powers of two");
      end
      if (IAW + 2 > 28 || DAW + 2 > 16) begin : g_too_deep
         $error("sc_cpu: memory depth exceeds addressable range");
      end
   endgenerate

   logic [XLEN-1:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];

   initial begin
      for (int i = 0; i < IMEM_WORDS; i++) imem[i] <= '0;
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, j_tgt;
   logic [XLEN-1:0] instr, sext, rs_val, rt_val, alu_b, alu_y, load_word, wb_data;
   logic [RAW-1:0]  wb_addr;
   logic [DAW-1:0]  mem_idx;
   logic            alu_zero, take_br, wb_en;
   ctrl_t           ctrl;

   assign instr    = imem[pc_q[2 +: IAW]];
   assign pc_plus4 = pc_q + 32'd4;
   assign sext     = {{16{instr[15]}}, instr[15:0]};
   assign br_tgt   = pc_plus4 + {sext[XLEN-3:0], 2'b00};
   assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

   sc_decode u_dec (
      .opcode (instr[31:26]),
      .funct  (instr[5:0]),
      .ctrl   (ctrl)
   );

   sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (wb_en),
      .wa  (wb_addr),
      .wd  (wb_data),
      .ra1 (instr[25:21]),
      .ra2 (instr[20:16]),
      .rd1 (rs_val),
      .rd2 (rt_val)
   );

   assign alu_b = ctrl.use_imm ? sext : rt_val;

   sc_alu #(.W(XLEN), .SLT_SIGNED(1'b1)) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .fn   (ctrl.fn),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign mem_idx   = alu_y[2 +: DAW];
   assign load_word = dmem[mem_idx];
   assign wb_addr   = ctrl.dst_rd ? instr[15:11] : instr[20:16];
   assign wb_data   = ctrl.mem_rd ? load_word : alu_y;
   assign wb_en     = ctrl.reg_we && (wb_addr != '0);
   assign take_br   = ctrl.is_beq && alu_zero;

   always_comb begin
      if (ctrl.is_jmp)   pc_next = j_tgt;
      else if (take_br)  pc_next = br_tgt;
      else               pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   always_ff @(posedge clk) begin
      if (!rst && ctrl.mem_we) dmem[mem_idx] <= rt_val;
   end

   assign pc_o      = pc_q;
   assign wb_en_o   = wb_en;
   assign wb_addr_o = wb_addr;
   assign wb_data_o = wb_data;

   logic unused_bits;
   assign unused_bits = ^{instr[10:6], pc_q[1:0], alu_y[1:0], alu_y[XLEN-1:DAW+2]};

   AST_RESET_PC: assert property (@(posedge clk)
      rst |=> pc_o == '0); // R1
   AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
      !(ctrl.is_jmp || (ctrl.is_beq && rs_val == rt_val)) |=> pc_o == $past(pc_o) + 32'd4); // R2
   AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (rst)
      (ctrl.is_beq && rs_val == rt_val) |=>
         pc_o == $past(pc_o) + 32'd4 + {$past(sext[XLEN-3:0]), 2'b00}); // R7
   AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
      ctrl.is_jmp |=> pc_o[27:0] == {$past(instr[25:0]), 2'b00}); // R8
   AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OPC_STOR) |-> !wb_en_o); // R6

endmodule

// File: tb/sc_cpu_test.sv
module sc_cpu_test;

   localparam int IMEM_WORDS = 256;
   localparam int DMEM_WORDS = 64;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_o;
   logic        wb_en_o;
   logic [4:0]  wb_addr_o;
   logic [31:0] wb_data_o;

   int checks   = 0;
   int failures = 0;

   logic [31:0] m_imem [IMEM_WORDS];
   logic [31:0] m_dmem [DMEM_WORDS];
   logic [31:0] m_reg  [32];
   logic [31:0] m_pc;

   always #4 clk = ~clk;

   sc_cpu #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) uut (
      .clk       (clk),
      .rst       (rst),
      .pc_o      (pc_o),
      .wb_en_o   (wb_en_o),
      .wb_addr_o (wb_addr_o),
      .wb_data_o (wb_data_o)
   );

   function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_j(logic [25:0] idx);
      return {6'h02, idx};
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: %s got %h exp %h", tag, what, act, exp);
      end
   endtask

   // One instruction of the reference model: compare the ports, then advance.
   task automatic step();
      logic [31:0] ins, a, b, sx, npc, data, addr_sum;
      logic [4:0]  dst;
      logic        en, st;
      string       tag;
      ins = m_imem[m_pc[9:2]];
      a   = (ins[25:21] == 0) ? 32'd0 : m_reg[ins[25:21]];
      b   = (ins[20:16] == 0) ? 32'd0 : m_reg[ins[20:16]];
      sx  = {{16{ins[15]}}, ins[15:0]};
      addr_sum = a + sx;
      npc = m_pc + 32'd4;
      en = 1'b0; st = 1'b0; dst = 5'd0; data = 32'd0; tag = "R10";
      case (ins[31:26])
         6'h00: begin
            dst = ins[15:11]; en = 1'b1; tag = "R3";
            case (ins[5:0])
               6'h20: data = a + b;
               6'h22: data = a - b;
               6'h24: data = a & b;
               6'h25: data = a | b;
               6'h2A: begin data = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
               default: begin en = 1'b0; tag = "R10"; end
            endcase
         end
         6'h23: begin dst = ins[20:16]; en = 1'b1; data = m_dmem[addr_sum[7:2]]; tag = "R5"; end
         6'h2B: begin st = 1'b1; tag = "R6"; end
         6'h04: begin tag = "R7"; if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00}; end
         6'h02: begin tag = "R8"; npc = {npc[31:28], ins[25:0], 2'b00}; end
         default: tag = "R10";
      endcase
      if (en && dst == 5'd0) begin en = 1'b0; tag = "R9"; end
      check(tag, "pc", pc_o, m_pc);
      check(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, en});
      if (en) begin
         check(tag, "wb_addr", {27'd0, wb_addr_o}, {27'd0, dst});
         check(tag, "wb_data", wb_data_o, data);
         m_reg[dst] = data;
      end
      if (st) m_dmem[addr_sum[7:2]] = b;
      m_pc = npc;
   endtask

   // Hold reset, preload both arrays, release at a falling edge.
   task automatic restart();
      rst = 1'b1;
      for (int i = 0; i < IMEM_WORDS; i++) uut.imem[i] <= m_imem[i];
      for (int i = 0; i < DMEM_WORDS; i++) uut.dmem[i] <= m_dmem[i];
      for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
      m_pc = 32'd0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         step();
         @(negedge clk);
      end
   endtask

   initial begin
      #(WATCHDOG * 8);
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));

      // Directed program: signed extremes, overflow, r0 writes, taken and skipped branches.
      for (int i = 0; i < IMEM_WORDS; i++) m_imem[i] = 32'd0;
      for (int i = 0; i < DMEM_WORDS; i++) m_dmem[i] = 32'h1000 + i;
      m_dmem[0] = 32'h7FFF_FFFF;
      m_dmem[1] = 32'h8000_0000;
      m_imem[0]  = enc_r(6'h25, 5'd11, 5'd12, 5'd10);       // R1 regs clear
      m_imem[1]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
      m_imem[2]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
      m_imem[3]  = enc_r(6'h2A, 5'd1, 5'd2, 5'd3);          // R4 -> 0
      m_imem[4]  = enc_r(6'h2A, 5'd2, 5'd1, 5'd4);          // R4 -> 1
      m_imem[5]  = enc_r(6'h20, 5'd1, 5'd1, 5'd5);          // R3 overflow wrap
      m_imem[6]  = enc_r(6'h22, 5'd0, 5'd1, 5'd6);
      m_imem[7]  = enc_r(6'h20, 5'd1, 5'd2, 5'd0);          // R9 dropped
      m_imem[8]  = enc_i(6'h2B, 5'd2, 5'd4, 16'hFFFC);      // R6 negative offset
      m_imem[9]  = enc_i(6'h23, 5'd2, 5'd7, 16'hFFFC);      // R5 read back
      m_imem[10] = enc_i(6'h04, 5'd3, 5'd0, 16'd1);         // R7 taken
      m_imem[11] = enc_r(6'h20, 5'd1, 5'd1, 5'd8);
      m_imem[12] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);         // R7 not taken
      m_imem[13] = enc_r(6'h24, 5'd5, 5'd2, 5'd9);
      m_imem[14] = enc_j(26'h40);                           // R8
      m_imem[64] = {6'h3F, 26'h123_4567};                   // R10 bad opcode
      m_imem[65] = enc_r(6'h21, 5'd1, 5'd2, 5'd12);         // R10 bad funct
      m_imem[66] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFC0);      // R7 backward to 3
      restart();
      check("R1", "pc after reset", pc_o, 32'd0);
      check("R1", "wb_data from cleared regs", wb_data_o, 32'd0);
      run(60);

      // Random programs over eight registers.
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < IMEM_WORDS; i++) begin
            logic [4:0]  rs, rt, rd;
            logic [15:0] im;
            int pick;
            rs = 5'($urandom % 8); rt = 5'($urandom % 8); rd = 5'($urandom % 8);
            im = 16'($urandom);
            pick = $urandom % 14;
            case (pick)
               0, 1:    m_imem[i] = enc_r(6'h20, rs, rt, rd);
               2:       m_imem[i] = enc_r(6'h22, rs, rt, rd);
               3:       m_imem[i] = enc_r(6'h24, rs, rt, rd);
               4:       m_imem[i] = enc_r(6'h25, rs, rt, rd);
               5:       m_imem[i] = enc_r(6'h2A, rs, rt, rd);
               6, 7, 8: m_imem[i] = enc_i(6'h23, rs, rt, im);
               9, 10:   m_imem[i] = enc_i(6'h2B, rs, rt, im);
               11:      m_imem[i] = enc_i(6'h04, rs, rt, 16'($signed(($urandom % 17)) - 8));
               12:      m_imem[i] = enc_j(26'($urandom));
               default: m_imem[i] = ($urandom % 2) ? {6'h08, 26'($urandom)} : enc_r(6'h27, rs, rt, rd);
            endcase
         end
         for (int i = 0; i < DMEM_WORDS; i++) begin
            case (i % 8)
               0: m_dmem[i] = 32'h8000_0000;
               1: m_dmem[i] = 32'h7FFF_FFFF;
               2: m_dmem[i] = 32'hFFFF_FFFF;
               3: m_dmem[i] = 32'd0;
               default: m_dmem[i] = $urandom;
            endcase
         end
         restart();
         check("R1", "pc after reset", pc_o, 32'd0);
         run(1500);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule